// File: doc/BRIEF.md
# Multiplier Self-Test Sequencer

This block runs a built-in self-test on small combinational multipliers attached beside it. All attached units share one pair of operand buses driven by the block, and each unit returns its product on its own lane of a packed product bus. After a start pulse, the block walks an operand counter through one of three sweeps. Two sweeps are reduced: one holds the upper half of operand A at zero, and the other holds the upper half of operand B at zero. The third sweep applies every operand pair.

Each clock applies one vector. The selected unit's product is checked against a reference product that the block computes itself. The mismatch flag is registered, and any mismatch latches a fail flag. When the sweep has finished and the last comparison has landed, the block raises done together with either pass or fail. It holds that result until the next start is accepted, so it is then ready to test another unit.

A manual mode bypasses the sequencer. The operands typed in are placed directly on the shared buses, and the chosen unit's product appears on the output with no clock delay.

Top module: `mul_bist_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `fail` are low, and `op_a`/`op_b` are zero while `manual_en` is low.
- R2: With `mode` = 2'b00, an accepted start applies 64 distinct operand pairs, one per clock while `busy` is high, all with `op_a[3:2]` = 0.
- R3: With `mode` = 2'b01, an accepted start applies 64 distinct operand pairs, one per clock while `busy` is high, all with `op_b[3:2]` = 0.
- R4: With `mode` = 2'b10 or 2'b11, an accepted start applies all 256 operand pairs, one per clock while `busy` is high.
- R5: `busy` stays high for exactly the number of vectors in the sweep. In the cycle after `busy` falls, `done` is still low. `done` goes high one cycle later.
- R6: The reference product is the unsigned 8-bit product for units 1 and 2 and the two's-complement product for unit 3. If any swept vector mismatches, the run ends with `fail` = 1 and `pass` = 0. Otherwise it ends with `pass` = 1 and `fail` = 0.
- R7: Once `done` is high, `done`, `pass` and `fail` hold their values until the next accepted start, whatever `unit_sel` and `mode` do. An accepted start clears the previous result.
- R8: A start pulse while `busy` is high is ignored. The sweep length, and the unit and mode in use, stay as they were when the run began.
- R9: A start with `unit_sel` = 0 applies no vectors. On the next clock it gives `done` = 1, `fail` = 1, `pass` = 0.
- R10: While `manual_en` is high and `busy` is low, `op_a`/`op_b` equal `man_a`/`man_b` and `prod_out` shows the selected unit's product in the same cycle. A start is not accepted while `manual_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (one-cycle pulse) |
| mode | input | 2 | Sweep: 00 low-A, 01 low-B, 10/11 full |
| unit_sel | input | 2 | Unit under test, 1..3; 0 selects none |
| manual_en | input | 1 | Manual pass-through enable |
| man_a | input | 4 | Manual operand A |
| man_b | input | 4 | Manual operand B |
| prod_in | input | 24 | Unit products; unit k occupies bits [8k-1:8k-8] |
| op_a | output | 4 | Shared operand A to all units |
| op_b | output | 4 | Shared operand B to all units |
| prod_out | output | 8 | Product of the selected unit |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | Run found no mismatch |
| fail | output | 1 | Run found a mismatch, or no unit was selected |

## Verification
The assertions assume that the attached units are purely combinational, so a product is settled in the same cycle as its operands. The bench models each unit as a continuous assignment from `op_a`/`op_b`, which keeps the stimulus within that assumption. The assertions also assume that `start` is a single-cycle pulse. The bench drives every start for exactly one cycle, at the falling edge, including the pulse it injects during a sweep. Faults are injected into the unit models at chosen operand pairs. These pairs are placed so that a reduced sweep misses them, which makes the sweep boundaries visible at the pass and fail outputs.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
   typedef enum logic [1:0] {
      SWEEP_LO_A     = 2'b00,
      SWEEP_LO_B     = 2'b01,
      SWEEP_FULL     = 2'b10,
      SWEEP_FULL_ALT = 2'b11
   } sweep_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_DONE = 2'b10
   } state_e;
endpackage

// File: rtl/mbist_tpg.sv
module mbist_tpg
   import mbist_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  sweep_e          mode,
   output logic [OP_W-1:0] gen_a,
   output logic [OP_W-1:0] gen_b,
   output logic            last
);
   localparam int H    = OP_W / 2;
   localparam int CW   = 2 * OP_W;
   localparam logic [CW-1:0] TERM_RED  = CW'((1 << (OP_W + H)) - 1);
   localparam logic [CW-1:0] TERM_FULL = '1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] term;

   always_comb begin
      case (mode)
         SWEEP_LO_A, SWEEP_LO_B: term = TERM_RED;
         default:                term = TERM_FULL;
      endcase
   end

   assign last = (cnt == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   always_comb begin
      case (mode)
         SWEEP_LO_A: begin
            gen_a = {{(OP_W-H){1'b0}}, cnt[OP_W +: H]};
            gen_b = cnt[0 +: OP_W];
         end
         SWEEP_LO_B: begin
            gen_a = cnt[H +: OP_W];
            gen_b = {{(OP_W-H){1'b0}}, cnt[0 +: H]};
         end
         default: begin
            gen_a = cnt[OP_W +: OP_W];
            gen_b = cnt[0 +: OP_W];
         end
      endcase
   end

   // R4
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt <= term));
endmodule

// File: rtl/mbist_ora.sv
module mbist_ora #(
   parameter int OP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              set_fail,
   input  logic              sample,
   input  logic              is_signed,
   input  logic [OP_W-1:0]   opa,
   input  logic [OP_W-1:0]   opb,
   input  logic [2*OP_W-1:0] prod,
   output logic              fail_q,
   output logic              pending
);
   localparam int PW = 2 * OP_W;

   logic [PW-1:0] ext_a, ext_b, gold;
   logic          mis_q;

   always_comb begin
      if (is_signed) begin
         ext_a = {{OP_W{opa[OP_W-1]}}, opa};
         ext_b = {{OP_W{opb[OP_W-1]}}, opb};
      end else begin
         ext_a = {{OP_W{1'b0}}, opa};
         ext_b = {{OP_W{1'b0}}, opb};
      end
      gold = ext_a * ext_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mis_q   <= 1'b0;
         pending <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         mis_q   <= sample && (prod != gold);
         pending <= sample;
         if (clear)                 fail_q <= set_fail;
         else if (pending && mis_q) fail_q <= 1'b1;
      end
   end

   // R6
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_q && !clear) |=> fail_q);
endmodule

// File: rtl/mbist_fsm.sv
module mbist_fsm
   import mbist_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   manual_en,
   input  logic   sel_none,
   input  logic   last,
   output state_e state,
   output logic   accept
);
   state_e nxt;

   assign accept = start && !manual_en && (state != ST_RUN);

   always_comb begin
      nxt = state;
      case (state)
         ST_RUN:  if (last) nxt = ST_DONE;
         default: if (accept) nxt = sel_none ? ST_DONE : ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R8
   start_in_run_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && start && !last) |=> (state == ST_RUN));
endmodule

// File: rtl/mul_bist_ctrl.sv
module mul_bist_ctrl
   import mbist_pkg::*;
#(
   parameter int          OP_W        = 4,
   parameter int          N_UNITS     = 3,
   parameter logic [2:0]  UNIT_SIGNED = 3'b100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [1:0]                mode,
   input  logic [1:0]                unit_sel,
   input  logic                      manual_en,
   input  logic [OP_W-1:0]           man_a,
   input  logic [OP_W-1:0]           man_b,
   input  logic [N_UNITS*2*OP_W-1:0] prod_in,
   output logic [OP_W-1:0]           op_a,
   output logic [OP_W-1:0]           op_b,
   output logic [2*OP_W-1:0]         prod_out,
   output logic                      busy,
   output logic                      done,
   output logic                      pass,
   output logic                      fail
);
   localparam int PW = 2 * OP_W;
   localparam int H  = OP_W / 2;

   if (OP_W < 2 || (OP_W % 2) != 0) begin : g_bad_width
      $error("mul_bist_ctrl: OP_W must be even and at least 2");
   end
   if (N_UNITS < 1 || N_UNITS > 3) begin : g_bad_units
      $error("mul_bist_ctrl: N_UNITS must lie in 1..3");
   end

   state_e        state;
   logic          accept, last, sel_none, pending, fail_q;
   logic [1:0]    sel_q, sel_idx;
   sweep_e        mode_q;
   logic [OP_W-1:0] gen_a, gen_b;
   logic [PW-1:0] prod_arr [N_UNITS];
   logic [PW-1:0] prod_sel;
   logic          sgn_sel;

   genvar g;
   for (g = 0; g < N_UNITS; g++) begin : g_lane
      assign prod_arr[g] = prod_in[g*PW +: PW];
   end

   assign sel_none = (unit_sel == 2'd0) || (int'(unit_sel) > N_UNITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 2'd0;
         mode_q <= SWEEP_LO_A;
      end else if (accept) begin
         sel_q  <= unit_sel;
         mode_q <= sweep_e'(mode);
      end
   end

   assign busy    = (state == ST_RUN);
   assign sel_idx = busy ? sel_q : unit_sel;

   always_comb begin
      prod_sel = '0;
      sgn_sel  = 1'b0;
      for (int u = 0; u < N_UNITS; u++) begin
         if (sel_idx == 2'(u + 1)) begin
            prod_sel = prod_arr[u];
            sgn_sel  = UNIT_SIGNED[u];
         end
      end
   end

   mbist_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .manual_en (manual_en),
      .sel_none  (sel_none),
      .last      (last),
      .state     (state),
      .accept    (accept)
   );

   mbist_tpg #(.OP_W(OP_W)) u_tpg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (busy),
      .mode  (mode_q),
      .gen_a (gen_a),
      .gen_b (gen_b),
      .last  (last)
   );

   mbist_ora #(.OP_W(OP_W)) u_ora (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .set_fail  (sel_none),
      .sample    (busy),
      .is_signed (sgn_sel),
      .opa       (op_a),
      .opb       (op_b),
      .prod      (prod_sel),
      .fail_q    (fail_q),
      .pending   (pending)
   );

   always_comb begin
      if (busy) begin
         op_a = gen_a;
         op_b = gen_b;
      end else if (manual_en) begin
         op_a = man_a;
         op_b = man_b;
      end else begin
         op_a = '0;
         op_b = '0;
      end
   end

   assign prod_out = prod_sel;
   assign done     = (state == ST_DONE) && !pending;
   assign pass     = done && !fail_q;
   assign fail     = done && fail_q;

   // R2
   lo_a_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == SWEEP_LO_A) |-> (op_a[OP_W-1:H] == '0));

   // R3
   lo_b_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == SWEEP_LO_B) |-> (op_b[OP_W-1:H] == '0));

   // R6
   verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass != fail));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !accept) |=> (done && $stable(pass) && $stable(fail)));

   // R10
   manual_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_en && !busy) |-> (op_a == man_a && op_b == man_b));
endmodule

// File: tb/tb_mul_bist_ctrl.sv
module tb_mul_bist_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] unit_sel = 2'd0;
   logic manual_en = 1'b0;
   logic [3:0] man_a = '0, man_b = '0;
   logic [23:0] prod_in;
   logic [3:0] op_a, op_b;
   logic [7:0] prod_out;
   logic busy, done, pass, fail;

   int nchk = 0, nfail = 0;
   bit finished = 0;

   // Fault injection controls for the unit models
   logic f1_en = 0, f2_en = 0, uns3 = 0;
   logic [3:0] f1_a = 4'd9, f1_b = 4'd2, f2_a = 4'd1, f2_b = 4'd12;
   logic [7:0] p1, p2, p3;

   always #2.5 clk = ~clk;

   always_comb begin
      p1 = {4'b0, op_a} * {4'b0, op_b};
      if (f1_en && op_a == f1_a && op_b == f1_b) p1 = p1 ^ 8'h10;
      p2 = {4'b0, op_a} * {4'b0, op_b};
      if (f2_en && op_a == f2_a && op_b == f2_b) p2 = p2 ^ 8'h01;
      if (uns3) p3 = {4'b0, op_a} * {4'b0, op_b};
      else      p3 = {{4{op_a[3]}}, op_a} * {{4{op_b[3]}}, op_b};
   end
   assign prod_in = {p3, p2, p1};

   mul_bist_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .unit_sel(unit_sel),
      .manual_en(manual_en), .man_a(man_a), .man_b(man_b), .prod_in(prod_in),
      .op_a(op_a), .op_b(op_b), .prod_out(prod_out), .busy(busy), .done(done),
      .pass(pass), .fail(fail)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(!busy && !done && !pass && !fail, "R1 flags after reset",
          {busy, done, pass, fail}, 0);
      chk(op_a == 0 && op_b == 0, "R1 operands idle", {op_a, op_b}, 0);
   endtask

   // Runs a sweep; poke_at >= 0 injects a start (with unit 0) mid-run
   task automatic run_sweep(input logic [1:0] sel, input logic [1:0] md, input int exp_n,
                            input bit exp_pass, input int poke_at, input string tag);
      logic [255:0] seen = '0;
      int n = 0, viol = 0;
      @(negedge clk);
      unit_sel = sel; mode = md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy && n < 1000) begin
         if (seen[{op_a, op_b}]) viol++;
         seen[{op_a, op_b}] = 1'b1;
         if (md == 2'b00 && op_a[3:2] != 0) viol++;
         if (md == 2'b01 && op_b[3:2] != 0) viol++;
         if (n == poke_at) begin
            start = 1'b1; unit_sel = 2'd0; mode = 2'b00;
         end
         n++;
         @(negedge clk);
         start = 1'b0;
      end
      chk(n == exp_n, {tag, " vector count"}, n, exp_n);
      chk(viol == 0, {tag, " operand constraint / repeat"}, viol, 0);
      chk($countones(seen) == exp_n, {tag, " distinct vectors"}, $countones(seen), exp_n);
      chk(!done, "R5 done low in drain cycle", done, 0);
      @(negedge clk);
      chk(done, "R5 done one cycle after drain", done, 1);
      chk(pass == exp_pass && fail == !exp_pass, {tag, " R6 verdict"}, {pass, fail},
          {exp_pass, !exp_pass});
   endtask

   task automatic t_hold();
      logic p0;
      p0 = pass;
      @(negedge clk);
      unit_sel = 2'd0; mode = 2'b11;
      repeat (4) @(negedge clk);
      chk(done && pass == p0 && fail == !p0, "R7 result held", {done, pass}, {1'b1, p0});
   endtask

   task automatic t_sel_none();
      @(negedge clk);
      unit_sel = 2'd0; mode = 2'b10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy, "R9 no vectors applied", busy, 0);
      chk(done && fail && !pass, "R9 done with fail", {done, fail, pass}, 3'b110);
   endtask

   task automatic t_manual();
      logic d0;
      d0 = done;
      @(negedge clk);
      manual_en = 1'b1; man_a = 4'd7; man_b = 4'd9; unit_sel = 2'd3;
      #1;
      chk(op_a == 7 && op_b == 9, "R10 operands pass through", {op_a, op_b}, {4'd7, 4'd9});
      chk(prod_out == 8'hCF, "R10 signed unit product", prod_out, 8'hCF);
      unit_sel = 2'd1;
      #1;
      chk(prod_out == 8'h3F, "R10 unsigned unit product", prod_out, 8'h3F);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!busy && done == d0, "R10 start ignored in manual", {busy, done}, {1'b0, d0});
      manual_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      run_sweep(2'd1, 2'b00, 64, 1'b1, -1, "R2 low-A clean");
      t_hold();
      run_sweep(2'd2, 2'b01, 64, 1'b1, -1, "R3 low-B clean");
      run_sweep(2'd3, 2'b10, 256, 1'b1, -1, "R4 full signed unit R6");
      f1_en = 1'b1;
      run_sweep(2'd1, 2'b00, 64, 1'b1, -1, "R2 fault outside low-A");
      run_sweep(2'd1, 2'b01, 64, 1'b0, -1, "R3 fault caught low-B");
      t_hold();
      run_sweep(2'd1, 2'b11, 256, 1'b0, -1, "R4 alt code fault");
      f1_en = 1'b0;
      run_sweep(2'd1, 2'b10, 256, 1'b1, -1, "R7 clear on new start");
      f2_en = 1'b1;
      run_sweep(2'd2, 2'b01, 64, 1'b1, -1, "R3 fault outside low-B");
      run_sweep(2'd2, 2'b10, 256, 1'b0, -1, "R6 fault unit 2");
      f2_en = 1'b0;
      uns3 = 1'b1;
      run_sweep(2'd3, 2'b10, 256, 1'b0, -1, "R6 signed reference");
      uns3 = 1'b0;
      run_sweep(2'd2, 2'b10, 256, 1'b1, 10, "R8 start during run");
      t_sel_none();
      run_sweep(2'd3, 2'b00, 64, 1'b1, -1, "R7 clears after sel0");
      t_manual();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule